// File: doc/BRIEF.md
# Half-Duplex Smart-Card Serial Transceiver

This block moves bytes across a single-wire, half-duplex smart-card link. The transmit side serialises a byte into a frame of one low start bit, eight data bits, an even parity bit and a high stop bit. The receive side watches the line, samples each bit at its centre and returns the decoded byte. Bit timing comes from an external tick at sixteen times the bit rate by default. No baud divider sits inside the block.

Two bit conventions are selectable. The direct convention sends data uninverted with bit 0 first. The inverse convention sends the complemented byte with bit 7 first, and the parity bit is complemented too. When error signalling is enabled, a receiver that finds bad parity pulls the line low for one bit time, starting half a bit after the parity bit ends. The transmitter then holds its completion event back by half a bit, so that it can sample that pulse from the far end and report it.

The receiver is held idle while the transmitter is busy, because on a shared wire it would otherwise hear its own frames. Configuration inputs must stay stable during a frame.

Top module: `scard_uart`

## Requirements
- R1: A synchronous active-high reset returns both directions to idle. After reset `txd` is high, `tx_ready` is high, and `tx_done`, `tx_err`, `rx_valid` and `rx_perr` are low. This holds even when reset arrives in the middle of a frame.
- R2: With `cfg_inverse`=0, a frame on `txd` has the following layout, each bit lasting OSR ticks:
  - slot 0 is low (start);
  - slots 1..8 carry data bit 0 through data bit 7, uninverted;
  - slot 9 carries the XOR of the eight data bits (even parity);
  - slot 10 is high (stop).
- R3: With `cfg_inverse`=1, slot 1+k carries the complement of data bit 7-k, and slot 9 carries the complement of the even parity bit. Start and stop levels are the same as in R2.
- R4: In the direct convention, a received frame raises `rx_valid` for one cycle with the byte on `rx_data`.
- R5: In the inverse convention, a received frame is decoded back to the original byte.
- R6: A received frame whose parity check fails still raises `rx_valid` with the decoded byte, and it also raises `rx_perr`.
- R7: With `cfg_err_sig`=1, a parity failure drives `txd` low for exactly OSR cycles at a tick per cycle. The pulse starts at the stop-bit centre, which is half a bit after the parity bit ends. Seen at the port, it starts 10*OSR+OSR/2+3 cycles after the start edge; the extra 3 cycles are the input synchroniser and edge detection.
- R8: With `cfg_err_sig`=0, no error pulse is driven, whatever the parity result.
- R9: `tx_done` pulses for one cycle after the parity bit ends. The delay is OSR/2 ticks when `cfg_err_sig`=0 and OSR ticks when `cfg_err_sig`=1.
- R10: `tx_err` pulses together with `tx_done` when the synchronised line is low at that point. Otherwise `tx_err` stays low.
- R11: A low level on the line that is no longer low at the start-bit centre is rejected. It produces no `rx_valid`.
- R12: `tx_ready` drops in the cycle after a byte is accepted. It returns after the stop bit, which lasts one bit time, or two bit times when `cfg_err_sig`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling tick, OSR per bit time |
| cfg_inverse | input | 1 | 1 selects the inverse bit convention |
| cfg_err_sig | input | 1 | 1 enables error pulses and delayed completion |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter idle and accepting |
| tx_done | output | 1 | One-cycle transmit completion pulse |
| tx_err | output | 1 | Far end signalled an error, valid with tx_done |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle pulse, new byte on rx_data |
| rx_perr | output | 1 | Parity failure, valid with rx_valid |
| rxd | input | 1 | Serial line input |
| txd | output | 1 | Serial line output, high when released |

## Verification
A wrong bit counter or slot index in the transmitter shows up within the same frame as a misplaced level at some bit centre, and every byte and both conventions are swept. A wrong receive shift position or convention decode corrupts `rx_data` at the `rx_valid` pulse of that frame. A wrong phase counter in the stop tail moves the `tx_done` pulse, the error-pulse start, or the error-pulse length by whole cycles, and each of these is measured exactly. A receiver that leaves its error or hold states badly either leaves `txd` low or raises a spurious `rx_valid` inside the same observation window.

// File: rtl/scu_pkg.sv
package scu_pkg;

   typedef enum logic [1:0] {
      TX_IDLE,
      TX_SHIFT,
      TX_TAIL
   } scu_tx_state_e;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_ERR,
      RX_HOLD
   } scu_rx_state_e;

   // logical bit to line level under the selected convention
   function automatic logic scu_level(input logic inv, input logic b);
      return inv ? ~b : b;
   endfunction

endpackage

// File: rtl/scu_conv.sv
// Maps a data word to line order and back; the map is its own inverse.
module scu_conv #(
   parameter int W = 8
) (
   input  logic         inv,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (W < 1) begin : g_bad_w
         $error("scu_conv: W must be at least 1");
      end
   endgenerate

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign dout[i] = inv ? ~din[W-1-i] : din[i];
      end
   endgenerate

endmodule

// File: rtl/scu_tx.sv
module scu_tx
   import scu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              inv,
   input  logic              err_en,
   input  logic              rx_s,
   input  logic [DATA_W-1:0] data,
   input  logic              valid,
   output logic              ready_o,
   output logic              busy_o,
   output logic              line_o,
   output logic              done_o,
   output logic              err_o
);

   localparam int FRAME_W = DATA_W + 2;
   localparam int PH_W    = $clog2(FRAME_W);
   localparam int CNT_W   = $clog2(2 * OSR);
   localparam logic [PH_W-1:0]  PH_LAST    = PH_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] BIT_END    = CNT_W'(OSR - 1);
   localparam logic [CNT_W-1:0] DONE_SHORT = CNT_W'(OSR / 2 - 1);
   localparam logic [CNT_W-1:0] DONE_LONG  = CNT_W'(OSR - 1);
   localparam logic [CNT_W-1:0] TAIL_SHORT = CNT_W'(OSR - 1);
   localparam logic [CNT_W-1:0] TAIL_LONG  = CNT_W'(2 * OSR - 1);

   generate
      if (OSR < 8 || (OSR % 2) != 0) begin : g_bad_osr
         $error("scu_tx: OSR must be even and at least 8");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("scu_tx: DATA_W must be at least 1");
      end
   endgenerate

   scu_tx_state_e       st_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [PH_W-1:0]     ph_q;
   logic [FRAME_W-1:0]  frame_q;
   logic [DATA_W-1:0]   enc;
   logic                par_line;
   logic [CNT_W-1:0]    done_pt;
   logic [CNT_W-1:0]    tail_end;

   scu_conv #(.W(DATA_W)) enc_i (
      .inv  (inv),
      .din  (data),
      .dout (enc)
   );

   assign par_line = scu_level(inv, ^data);
   assign done_pt  = err_en ? DONE_LONG : DONE_SHORT;
   assign tail_end = err_en ? TAIL_LONG : TAIL_SHORT;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= TX_IDLE;
         cnt_q   <= '0;
         ph_q    <= '0;
         frame_q <= '1;
         done_o  <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         case (st_q)
            TX_IDLE: begin
               if (valid) begin
                  frame_q <= {par_line, enc, 1'b0};
                  st_q    <= TX_SHIFT;
                  cnt_q   <= '0;
                  ph_q    <= '0;
               end
            end
            TX_SHIFT: begin
               if (tick) begin
                  if (cnt_q == BIT_END) begin
                     cnt_q <= '0;
                     if (ph_q == PH_LAST) begin
                        st_q <= TX_TAIL;
                     end else begin
                        ph_q <= ph_q + 1'b1;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            TX_TAIL: begin
               if (tick) begin
                  if (cnt_q == done_pt) begin
                     done_o <= 1'b1;
                     err_o  <= ~rx_s;
                  end
                  if (cnt_q == tail_end) begin
                     st_q  <= TX_IDLE;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: st_q <= TX_IDLE;
         endcase
      end
   end

   assign ready_o = (st_q == TX_IDLE);
   assign busy_o  = (st_q != TX_IDLE);
   assign line_o  = (st_q == TX_SHIFT) ? frame_q[ph_q] : 1'b1;

   // R12
   accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (valid && ready_o) |=> !ready_o);

   // R10
   err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
      err_o |-> done_o);

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

endmodule

// File: rtl/scu_rx.sv
module scu_rx
   import scu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              inv,
   input  logic              err_en,
   input  logic              hold,
   input  logic              rx_s,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o,
   output logic              perr_o,
   output logic              drv_o
);

   localparam int IDX_W = $clog2(DATA_W + 1);
   localparam int CNT_W = $clog2(OSR);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W);
   localparam logic [CNT_W-1:0] BIT_END  = CNT_W'(OSR - 1);
   localparam logic [CNT_W-1:0] HALF_END = CNT_W'(OSR / 2 - 1);

   generate
      if (OSR < 8 || (OSR % 2) != 0) begin : g_bad_osr
         $error("scu_rx: OSR must be even and at least 8");
      end
   endgenerate

   scu_rx_state_e     st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W:0]   sh_q;
   logic [DATA_W-1:0] dec;
   logic              par_bad;

   scu_conv #(.W(DATA_W)) dec_i (
      .inv  (inv),
      .din  (sh_q[DATA_W-1:0]),
      .dout (dec)
   );

   assign par_bad = ^{dec, scu_level(inv, sh_q[DATA_W])};

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= RX_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         sh_q    <= '0;
         data_o  <= '0;
         valid_o <= 1'b0;
         perr_o  <= 1'b0;
         drv_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         perr_o  <= 1'b0;
         case (st_q)
            RX_IDLE: begin
               if (tick && !rx_s && !hold) begin
                  st_q  <= RX_START;
                  cnt_q <= '0;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (cnt_q == HALF_END) begin
                     cnt_q <= '0;
                     idx_q <= '0;
                     st_q  <= rx_s ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            RX_DATA: begin
               if (tick) begin
                  if (cnt_q == BIT_END) begin
                     cnt_q       <= '0;
                     sh_q[idx_q] <= rx_s;
                     if (idx_q == IDX_LAST) begin
                        st_q <= RX_STOP;
                     end else begin
                        idx_q <= idx_q + 1'b1;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (tick) begin
                  if (cnt_q == BIT_END) begin
                     cnt_q   <= '0;
                     valid_o <= 1'b1;
                     data_o  <= dec;
                     perr_o  <= par_bad;
                     if (par_bad && err_en) begin
                        drv_o <= 1'b1;
                        st_q  <= RX_ERR;
                     end else begin
                        st_q <= RX_IDLE;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            RX_ERR: begin
               if (tick) begin
                  if (cnt_q == BIT_END) begin
                     cnt_q <= '0;
                     drv_o <= 1'b0;
                     st_q  <= RX_HOLD;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            RX_HOLD: begin
               if (rx_s) begin
                  st_q <= RX_IDLE;
               end
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end

   // R6
   perr_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
      perr_o |-> valid_o);

   // R8
   pulse_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(drv_o) |-> (err_en && perr_o));

   // R7
   pulse_release_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(drv_o) |-> !valid_o);

endmodule

// File: rtl/scard_uart.sv
module scard_uart #(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              os_tick,
   input  logic              cfg_inverse,
   input  logic              cfg_err_sig,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic              tx_done,
   output logic              tx_err,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_perr,
   input  logic              rxd,
   output logic              txd
);

   generate
      if (OSR < 8 || (OSR % 2) != 0) begin : g_bad_osr
         $error("scard_uart: OSR must be even and at least 8");
      end
   endgenerate

   logic [1:0] sync_q;
   logic       rx_s;
   logic       tx_busy;
   logic       tx_line;
   logic       rx_drv;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= 2'b11;
      end else begin
         sync_q <= {sync_q[0], rxd};
      end
   end

   assign rx_s = sync_q[1];

   scu_tx #(.DATA_W(DATA_W), .OSR(OSR)) tx_i (
      .clk     (clk),
      .rst     (rst),
      .tick    (os_tick),
      .inv     (cfg_inverse),
      .err_en  (cfg_err_sig),
      .rx_s    (rx_s),
      .data    (tx_data),
      .valid   (tx_valid),
      .ready_o (tx_ready),
      .busy_o  (tx_busy),
      .line_o  (tx_line),
      .done_o  (tx_done),
      .err_o   (tx_err)
   );

   scu_rx #(.DATA_W(DATA_W), .OSR(OSR)) rx_i (
      .clk     (clk),
      .rst     (rst),
      .tick    (os_tick),
      .inv     (cfg_inverse),
      .err_en  (cfg_err_sig),
      .hold    (tx_busy),
      .rx_s    (rx_s),
      .data_o  (rx_data),
      .valid_o (rx_valid),
      .perr_o  (rx_perr),
      .drv_o   (rx_drv)
   );

   assign txd = tx_line & ~rx_drv;

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (txd && tx_ready && !tx_done && !tx_err && !rx_valid));

   // R10
   err_only_at_done_chk: assert property (@(posedge clk) disable iff (rst)
      tx_err |-> (tx_done && cfg_err_sig));

endmodule

// File: tb/scard_uart_tb_top.sv
module scard_uart_tb_top;

   localparam int OSR = 8;

   logic       clk;
   logic       rst;
   logic       os_tick;
   logic       cfg_inverse;
   logic       cfg_err_sig;
   logic [7:0] tx_data;
   logic       tx_valid;
   logic       tx_ready;
   logic       tx_done;
   logic       tx_err;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic       rx_perr;
   logic       rxd;
   logic       txd;
   logic       card_drv;

   int n_run  = 0;
   int n_fail = 0;

   assign rxd = txd & card_drv;

   scard_uart #(.DATA_W(8), .OSR(OSR)) dut_i (
      .clk         (clk),
      .rst         (rst),
      .os_tick     (os_tick),
      .cfg_inverse (cfg_inverse),
      .cfg_err_sig (cfg_err_sig),
      .tx_data     (tx_data),
      .tx_valid    (tx_valid),
      .tx_ready    (tx_ready),
      .tx_done     (tx_done),
      .tx_err      (tx_err),
      .rx_data     (rx_data),
      .rx_valid    (rx_valid),
      .rx_perr     (rx_perr),
      .rxd         (rxd),
      .txd         (txd)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [10:0] exp_line(input logic [7:0] d, input bit inv);
      logic [10:0] l;
      l[0] = 1'b0;
      for (int i = 0; i < 8; i++) l[1+i] = inv ? ~d[7-i] : d[i];
      l[9]  = inv ? ~(^d) : ^d;
      l[10] = 1'b1;
      return l;
   endfunction

   task automatic run_tx(input logic [7:0] d, input bit inv, input bit een, input bit inject);
      logic [10:0] lvl;
      int done_m;
      int err_n;
      int done_exp;
      int end_m;
      lvl      = exp_line(d, inv);
      done_m   = -1;
      err_n    = 0;
      done_exp = 10*OSR + (een ? OSR : OSR/2);
      end_m    = 10*OSR + (een ? 2*OSR : OSR);
      @(negedge clk);
      cfg_inverse = inv;
      cfg_err_sig = een;
      tx_data     = d;
      tx_valid    = 1'b1;
      @(posedge clk);
      for (int m = 0; m <= 12*OSR + 2; m++) begin
         @(negedge clk);
         if (m == 0) begin
            tx_valid = 1'b0;
            chk("R12 ready low after accept", int'(tx_ready), 0);
         end
         card_drv = (inject && m >= 10*OSR + OSR/2 && m < 10*OSR + 3*OSR/2) ? 1'b0 : 1'b1;
         if ((m % OSR) == OSR/2 && (m / OSR) <= 10)
            chk(inv ? "R3 inverse slot level" : "R2 direct slot level",
                int'(txd), int'(lvl[m/OSR]));
         if (tx_done && done_m < 0) done_m = m;
         if (tx_err) err_n++;
         if (m == end_m - 1) chk("R12 ready still low in stop", int'(tx_ready), 0);
         if (m == end_m) begin
            chk("R12 ready back after stop", int'(tx_ready), 1);
            break;
         end
      end
      card_drv = 1'b1;
      chk("R9 done timing", done_m, done_exp);
      chk("R10 far-end error flag", err_n, (inject && een) ? 1 : 0);
   endtask

   task automatic run_rx(input logic [7:0] d, input bit inv, input bit een, input bit flip);
      logic [10:0] lvl;
      int nv;
      int got;
      int gp;
      int first_low;
      int lows;
      lvl = exp_line(d, inv);
      if (flip) lvl[9] = ~lvl[9];
      nv = 0; got = -1; gp = -1; first_low = -1; lows = 0;
      @(negedge clk);
      cfg_inverse = inv;
      cfg_err_sig = een;
      for (int m = 0; m <= 13*OSR; m++) begin
         if (m != 0) @(negedge clk);
         if (rx_valid) begin
            nv++;
            got = int'(rx_data);
            gp  = int'(rx_perr);
         end
         if (!txd) begin
            lows++;
            if (first_low < 0) first_low = m;
         end
         card_drv = (m < 11*OSR) ? lvl[m/OSR] : 1'b1;
      end
      card_drv = 1'b1;
      chk(inv ? "R5 inverse frame count" : "R4 direct frame count", nv, 1);
      chk(inv ? "R5 inverse decoded byte" : "R4 direct decoded byte", got, int'(d));
      chk("R6 parity flag", gp, flip ? 1 : 0);
      if (flip && een) begin
         chk("R7 pulse start", first_low, 10*OSR + OSR/2 + 3);
         chk("R7 pulse length", lows, OSR);
      end else begin
         chk("R8 no pulse driven", lows, 0);
      end
   endtask

   task automatic run_glitch(input int len);
      int nv;
      int lows;
      nv = 0; lows = 0;
      for (int m = 0; m <= 13*OSR; m++) begin
         @(negedge clk);
         if (rx_valid) nv++;
         if (!txd) lows++;
         card_drv = (m < len) ? 1'b0 : 1'b1;
      end
      card_drv = 1'b1;
      chk("R11 short low rejected", nv, 0);
      chk("R11 line untouched", lows, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired, actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst         = 1'b1;
      os_tick     = 1'b1;
      cfg_inverse = 1'b0;
      cfg_err_sig = 1'b0;
      tx_data     = 8'h00;
      tx_valid    = 1'b0;
      card_drv    = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R1 txd high in reset", int'(txd), 1);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 txd idle", int'(txd), 1);
      chk("R1 tx_ready idle", int'(tx_ready), 1);
      chk("R1 tx_done idle", int'(tx_done), 0);
      chk("R1 tx_err idle", int'(tx_err), 0);
      chk("R1 rx_valid idle", int'(rx_valid), 0);
      chk("R1 rx_perr idle", int'(rx_perr), 0);

      // exhaustive transmit sweep, both conventions
      for (int inv = 0; inv < 2; inv++)
         for (int d = 0; d < 256; d++)
            run_tx(8'(d), bit'(inv), 1'b0, 1'b0);

      // delayed completion, with and without a far-end error pulse
      for (int k = 0; k < 8; k++) begin
         run_tx(8'(k * 37 + 5), bit'(k & 1), 1'b1, 1'b0);
         run_tx(8'(k * 53 + 9), bit'(k & 1), 1'b1, 1'b1);
      end

      // exhaustive receive sweep, both conventions
      for (int inv = 0; inv < 2; inv++)
         for (int d = 0; d < 256; d++)
            run_rx(8'(d), bit'(inv), 1'b0, 1'b0);

      // parity failures with error signalling on and off
      for (int k = 0; k < 16; k++) begin
         run_rx(8'(k * 17 + 3), bit'(k & 1), 1'b1, 1'b1);
         run_rx(8'(k * 29 + 1), bit'(k & 1), 1'b0, 1'b1);
         run_rx(8'(k * 11 + 7), bit'(k & 1), 1'b1, 1'b0);
      end

      // low levels too short to be a start bit
      for (int len = 1; len <= 3; len++) run_glitch(len);

      // reset in the middle of a transmitted frame
      @(negedge clk);
      cfg_inverse = 1'b0;
      cfg_err_sig = 1'b0;
      tx_data     = 8'h00;
      tx_valid    = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      repeat (30) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 txd after mid-frame reset", int'(txd), 1);
      chk("R1 ready after mid-frame reset", int'(tx_ready), 1);
      repeat (2 * OSR) @(negedge clk);
      chk("R1 line stays released", int'(txd), 1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule